// File: doc/BRIEF.md
# ARINC 429 Queued Word Transmitter

This block takes 31-bit ARINC 429 words from a 16-bit host bus, one word per pair of load strobes (lower half, then upper half), and keeps up to eight of them in a first-in first-out queue. While the transmit enable is high it sends the queued words, oldest first, as return-to-zero pulses on two lines: one line pulses for a logic one and the other for a logic zero. A parity bit is added as bit 32 of each frame. All timing is counted in cycles of the master clock, which is nominally 1 MHz. A rate select picks a bit period of 10 clocks (high speed) or 80 clocks (low speed).

A ready flag is high only when nothing is queued and nothing is being sent. A free-running divided clock output shows the selected bit rate. A received word can be repeated by driving the two load strobes from the read cycles of a receiver's byte readout.

The sequencer has four states. ST_IDLE waits. ST_MARK drives the current bit on its line. ST_SPACE holds both lines low. ST_GAP is the inter-word null. The transitions are:
- IDLE to MARK: start.
- MARK to SPACE: half a bit period has elapsed.
- SPACE to MARK: the next bit begins.
- SPACE to GAP: bit 32 has finished.
- GAP to MARK: back-to-back start.
- GAP to IDLE: the gap has ended and no start is taken.

A start is taken when the enable is high and the queue is not empty.

Top module: `arinc_tx_queue`

## Requirements
- R1: A word enters the queue only when a byte-2 strobe (`hi_stb`) follows a byte-1 strobe (`lo_stb`). A `hi_stb` with no pending `lo_stb`, or one in the same cycle as `lo_stb`, is ignored, and `tx_ready` stays high.
- R2: The queue holds 8 words. A load that completes while 8 words are queued is dropped, so only the first 8 of 9 loads are sent.
- R3: `tx_ready` falls in the cycle after a word is accepted. It rises again only once the queue is empty and the sequencer has returned to ST_IDLE after the gap. While it is high, both lines are low.
- R4: When `tx_go` is high in ST_IDLE with a word queued, bit 1 of that word is on a line in the very next cycle. With `tx_go` low, queued words wait.
- R5: At high speed (`slow_rate`=0), each bit is 5 clocks of pulse followed by 5 clocks of null. After bit 32 there is a 40-clock gap, so the low time between the last pulse of one word and the first pulse of the next is 45 clocks.
- R6: At low speed (`slow_rate`=1), the same figures are 40, 40 and 320 clocks, giving 360 clocks between words. The rate is sampled when a word starts and holds for the whole frame.
- R7: Bit 32 makes the total count of ones in the frame odd when `par_even`=0 and even when `par_even`=1. `par_even` is sampled at word start.
- R8: ARINC bit 1 is sent first. The bus bits map to ARINC bits as follows:
  - Byte-1 bus bits 7..0 are ARINC bits 1..8.
  - Byte-1 bus bits 11..15 are ARINC bits 9..13.
  - Byte-1 bus bit 9 is ARINC bit 30, and byte-1 bus bit 10 is ARINC bit 31.
  - Byte-1 bus bit 8 (the bit-32 position) is ignored.
  - Byte-2 bus bits 0..15 are ARINC bits 14..29.
- R9: Asserting `rst_n` low at once drops both lines low, sets `tx_ready` high and empties the queue. After release, no word is sent even with `tx_go` high.
- R10: `tick_out` repeats every 10 or 80 clocks (by `slow_rate`). It is high for the first half of each period, measured from a counter that is reset to 0.
- R11: A word loaded while a frame is going out is queued behind it and does not alter the frame in flight.
- R12: `line_one` and `line_zero` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| lo_stb | input | 1 | Byte-1 load strobe, one cycle |
| hi_stb | input | 1 | Byte-2 load strobe, one cycle |
| bus_in | input | 16 | Host data bus |
| tx_go | input | 1 | Transmit enable |
| slow_rate | input | 1 | 0: divide by 10, 1: divide by 80 |
| par_even | input | 1 | 0: odd parity, 1: even parity |
| line_one | output | 1 | Pulses for a one bit |
| line_zero | output | 1 | Pulses for a zero bit |
| tx_ready | output | 1 | High when the queue and sequencer are idle |
| tick_out | output | 1 | Divided bit-rate clock |

## Verification
The assertions assume that strobes are synchronous single-cycle pulses. They also assume that `hi_stb` is meant to complete a word only after a separate `lo_stb` cycle, and that reset is the only way to abort a frame. The stimulus follows these assumptions: every input changes on the falling clock edge, each strobe lasts exactly one cycle, and `lo_stb` always leads `hi_stb` by a cycle except in the deliberate orphan-strobe case. `tx_go` and `slow_rate` are allowed to change in the middle of a frame, so the per-word sampling of the rate is exercised.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;
    localparam int BUS_W   = 16;
    localparam int WORD_W  = 31;
    localparam int FRAME_W = WORD_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_SPACE,
        ST_GAP
    } tx_state_t;
endpackage

// File: rtl/arinc_tx_loader.sv
module arinc_tx_loader
    import arinc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_stb,
    input  logic              hi_stb,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              push,
    output logic [WORD_W-1:0] word
);
    logic [BUS_W-1:0] held;
    logic             pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held    <= '0;
            pending <= 1'b0;
        end else if (lo_stb) begin
            held    <= bus_in;
            pending <= 1'b1;
        end else if (hi_stb) begin
            pending <= 1'b0;
        end
    end

    assign push = hi_stb && pending && !lo_stb;

    // word[k-1] carries ARINC bit k
    for (genvar k = 1; k <= 8; k++) begin : g_label
        assign word[k-1] = held[8-k];
    end
    for (genvar k = 9; k <= 13; k++) begin : g_sdi
        assign word[k-1] = held[k+2];
    end
    for (genvar k = 14; k <= 29; k++) begin : g_upper
        assign word[k-1] = bus_in[k-14];
    end
    assign word[29] = held[9];
    assign word[30] = held[10];
endmodule

// File: rtl/arinc_tx_fifo.sv
module arinc_tx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_wr, do_rd;

    assign empty  = (count == '0);
    assign full   = (count == CNT_W'(DEPTH));
    assign do_wr  = wr_en && !full;
    assign do_rd  = rd_en && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
            count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> $stable(count));

    // R2
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/arinc_tx_rate.sv
module arinc_tx_rate #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    output logic tick_out
);
    localparam int CW = $clog2(DIV_SLOW);

    logic [CW-1:0] cnt;
    logic [CW-1:0] div;

    assign div      = slow ? CW'(DIV_SLOW) : CW'(DIV_FAST);
    assign tick_out = (cnt < (div >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (cnt >= div - 1'b1) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/arinc_tx_queue.sv
module arinc_tx_queue
    import arinc_tx_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_stb,
    input  logic             hi_stb,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             tx_go,
    input  logic             slow_rate,
    input  logic             par_even,
    output logic             line_one,
    output logic             line_zero,
    output logic             tx_ready,
    output logic             tick_out
);
    localparam int PH_W  = $clog2(GAP_BITS * DIV_SLOW);
    localparam int BIT_W = $clog2(FRAME_W);

    logic              push, empty, full, start, parity;
    logic [WORD_W-1:0] in_word, head_word;

    tx_state_t          state, state_nx;
    logic [PH_W-1:0]    phase, phase_nx, half_len, gap_len;
    logic [BIT_W-1:0]   bitn, bitn_nx;
    logic [FRAME_W-1:0] shreg, shreg_nx;
    logic               slow_w, slow_w_nx;

    arinc_tx_loader u_loader (
        .clk(clk), .rst_n(rst_n), .lo_stb(lo_stb), .hi_stb(hi_stb),
        .bus_in(bus_in), .push(push), .word(in_word)
    );

    arinc_tx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(in_word),
        .rd_en(start), .rd_data(head_word), .empty(empty), .full(full)
    );

    arinc_tx_rate #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rate (
        .clk(clk), .rst_n(rst_n), .slow(slow_rate), .tick_out(tick_out)
    );

    assign half_len = slow_w ? PH_W'(DIV_SLOW/2) : PH_W'(DIV_FAST/2);
    assign gap_len  = slow_w ? PH_W'(GAP_BITS*DIV_SLOW) : PH_W'(GAP_BITS*DIV_FAST);
    assign parity   = par_even ^ ~(^head_word);
    assign start    = tx_go && !empty &&
                      (state == ST_IDLE ||
                       (state == ST_GAP && phase == gap_len - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            phase  <= '0;
            bitn   <= '0;
            shreg  <= '0;
            slow_w <= 1'b0;
        end else begin
            state  <= state_nx;
            phase  <= phase_nx;
            bitn   <= bitn_nx;
            shreg  <= shreg_nx;
            slow_w <= slow_w_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        phase_nx  = phase + 1'b1;
        bitn_nx   = bitn;
        shreg_nx  = shreg;
        slow_w_nx = slow_w;
        if (start) begin
            state_nx  = ST_MARK;
            phase_nx  = '0;
            bitn_nx   = '0;
            shreg_nx  = {parity, head_word};
            slow_w_nx = slow_rate;
        end else begin
            unique case (state)
                ST_IDLE: phase_nx = '0;
                ST_MARK: begin
                    if (phase == half_len - 1'b1) begin
                        state_nx = ST_SPACE;
                        phase_nx = '0;
                    end
                end
                ST_SPACE: begin
                    if (phase == half_len - 1'b1) begin
                        phase_nx = '0;
                        if (bitn == BIT_W'(FRAME_W-1)) begin
                            state_nx = ST_GAP;
                        end else begin
                            state_nx = ST_MARK;
                            bitn_nx  = bitn + 1'b1;
                            shreg_nx = {1'b0, shreg[FRAME_W-1:1]};
                        end
                    end
                end
                ST_GAP: begin
                    if (phase == gap_len - 1'b1) begin
                        state_nx = ST_IDLE;
                        phase_nx = '0;
                    end
                end
            endcase
        end
    end

    always_comb begin
        line_one  = (state == ST_MARK) &&  shreg[0];
        line_zero = (state == ST_MARK) && !shreg[0];
        tx_ready  = (state == ST_IDLE) && empty;
    end

    // R12
    lines_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_one, line_zero}));

    // R3
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> $past(push));

    // R3
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!line_one && !line_zero));

    // R4
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tx_go && !empty) |=> (line_one || line_zero));
endmodule

// File: tb/arinc_tx_queue_tb.sv
module arinc_tx_queue_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lo_stb = 1'b0, hi_stb = 1'b0;
    logic [15:0] bus_in = '0;
    logic        tx_go = 1'b0, slow_rate = 1'b0, par_even = 1'b0;
    logic        line_one, line_zero, tx_ready, tick_out;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    arinc_tx_queue dut_i (
        .clk(clk), .rst_n(rst_n), .lo_stb(lo_stb), .hi_stb(hi_stb),
        .bus_in(bus_in), .tx_go(tx_go), .slow_rate(slow_rate),
        .par_even(par_even), .line_one(line_one), .line_zero(line_zero),
        .tx_ready(tx_ready), .tick_out(tick_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // word bit k-1 is ARINC bit k
    function automatic logic [30:0] build(input logic [15:0] b1, input logic [15:0] b2);
        logic [30:0] w = '0;
        for (int k = 1; k <= 31; k++) begin
            if (k <= 8)       w[k-1] = b1[8-k];
            else if (k <= 13) w[k-1] = b1[k+2];
            else if (k <= 29) w[k-1] = b2[k-14];
            else if (k == 30) w[k-1] = b1[9];
            else              w[k-1] = b1[10];
        end
        return w;
    endfunction

    function automatic logic [31:0] frame(input logic [15:0] b1, input logic [15:0] b2, input bit even);
        logic [30:0] w = build(b1, b2);
        int ones = 0;
        for (int i = 0; i < 31; i++) ones += int'(w[i]);
        return {((ones % 2) == 0) ^ even, w};
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [30:0] mq[$];
    int          m_st = 0, m_ph = 0, m_bit = 0, m_cnt = 0;
    logic [31:0] m_fr = '0;
    bit          m_slow = 0, m_pend = 0;
    logic [15:0] m_held = '0;

    always @(posedge clk) begin
        int dn, hf, gl, dv;
        bit strt, psh, fullb;
        logic [30:0] w;
        if (!rst_n) begin
            mq.delete(); m_st = 0; m_ph = 0; m_bit = 0; m_cnt = 0;
            m_fr = '0; m_slow = 0; m_pend = 0; m_held = '0;
        end else begin
            dn = m_slow ? 80 : 10; hf = dn / 2; gl = 4 * dn;
            fullb = (mq.size() >= 8);
            psh   = hi_stb && m_pend && !lo_stb;
            strt  = tx_go && mq.size() > 0 && (m_st == 0 || (m_st == 3 && m_ph == gl - 1));
            if (strt) begin
                w = mq.pop_front();
                m_fr = frame_of(w, par_even);
                m_slow = slow_rate; m_st = 1; m_ph = 0; m_bit = 0;
            end else begin
                case (m_st)
                    1: if (m_ph == hf - 1) begin m_st = 2; m_ph = 0; end else m_ph++;
                    2: if (m_ph == hf - 1) begin
                           m_ph = 0;
                           if (m_bit == 31) m_st = 3; else begin m_st = 1; m_bit++; end
                       end else m_ph++;
                    3: if (m_ph == gl - 1) begin m_st = 0; m_ph = 0; end else m_ph++;
                    default: ;
                endcase
            end
            if (psh && !fullb) mq.push_back(build(m_held, bus_in));
            if (lo_stb) begin m_held = bus_in; m_pend = 1; end
            else if (hi_stb) m_pend = 0;
            dv = slow_rate ? 80 : 10;
            m_cnt = (m_cnt >= dv - 1) ? 0 : m_cnt + 1;
        end
    end

    function automatic logic [31:0] frame_of(input logic [30:0] w, input bit even);
        int ones = 0;
        for (int i = 0; i < 31; i++) ones += int'(w[i]);
        return {((ones % 2) == 0) ^ even, w};
    endfunction

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(line_one  == (m_st == 1 &&  m_fr[m_bit]), "R5 line_one model", int'(line_one),  int'(m_st == 1 &&  m_fr[m_bit]));
            check(line_zero == (m_st == 1 && !m_fr[m_bit]), "R5 line_zero model", int'(line_zero), int'(m_st == 1 && !m_fr[m_bit]));
            check(tx_ready  == (m_st == 0 && mq.size() == 0), "R3 ready model", int'(tx_ready), int'(m_st == 0 && mq.size() == 0));
            check(tick_out  == (m_cnt < ((slow_rate ? 80 : 10) / 2)), "R10 tick model", int'(tick_out), int'(m_cnt < ((slow_rate ? 80 : 10) / 2)));
        end
    end

    // ---------------- line monitor ----------------
    int clr_req = 0, clr_seen = 0;
    logic [31:0] rx_words [16];
    int rx_cnt = 0, rx_pos = 0;
    logic [31:0] rx_w = '0;
    bit prev_act = 0, seen = 0;
    int hi_run = 0, lo_run = 0, hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;

    always @(negedge clk) begin
        bit act;
        act = line_one || line_zero;
        if (clr_seen != clr_req) begin
            clr_seen = clr_req; rx_cnt = 0; rx_pos = 0; rx_w = '0; seen = 0;
            hi_min = 99999; hi_max = 0; lo_min = 99999; lo_max = 0;
        end
        if (!rst_n) begin
            rx_pos = 0; rx_w = '0; prev_act = 0; seen = 0;
        end else begin
            if (act && !prev_act) begin
                if (seen) begin
                    if (lo_run < lo_min) lo_min = lo_run;
                    if (lo_run > lo_max) lo_max = lo_run;
                end
                rx_w[rx_pos] = line_one;
                rx_pos++;
                if (rx_pos == 32) begin
                    if (rx_cnt < 16) rx_words[rx_cnt] = rx_w;
                    rx_cnt++; rx_pos = 0; rx_w = '0;
                end
                seen = 1; hi_run = 1;
            end else if (act) begin
                hi_run++;
            end else if (prev_act) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                lo_run = 1;
            end else begin
                lo_run++;
            end
            prev_act = act;
        end
    end

    task automatic clear_mon();
        clr_req++;
        @(negedge clk);
    endtask

    task automatic load_word(input logic [15:0] b1, input logic [15:0] b2);
        @(negedge clk); lo_stb = 1'b1; bus_in = b1;
        @(negedge clk); lo_stb = 1'b0; hi_stb = 1'b1; bus_in = b2;
        @(negedge clk); hi_stb = 1'b0; bus_in = '0;
    endtask

    task automatic wait_ready(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (tx_ready) break;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] wa1, wa2;
        int ticks;
        bit prev_t;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(tx_ready == 1'b1, "R9 ready in reset", int'(tx_ready), 1);
        check(!line_one && !line_zero, "R9 lines in reset", int'({line_one, line_zero}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 orphan byte-2 strobe
        hi_stb = 1'b1; bus_in = 16'hFFFF;
        @(negedge clk); hi_stb = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_ready == 1'b1, "R1 orphan hi_stb ignored", int'(tx_ready), 1);

        // R4 R5 R7 R8 single fast word, odd parity
        clear_mon();
        wa1 = 16'hA5C3; wa2 = 16'h1234;
        load_word(wa1, wa2);
        check(tx_ready == 1'b0, "R3 ready low after load", int'(tx_ready), 0);
        repeat (5) @(negedge clk);
        check(!line_one && !line_zero, "R4 held while tx_go low", int'({line_one, line_zero}), 0);
        tx_go = 1'b1;
        @(negedge clk);
        check(line_one || line_zero, "R4 first bit next cycle", int'({line_one, line_zero}), 1);
        wait_ready(2000);
        check(rx_cnt == 1, "R8 one word sent", rx_cnt, 1);
        check(rx_words[0] == frame(wa1, wa2, 1'b0), "R8 R7 odd frame", int'(rx_words[0]), int'(frame(wa1, wa2, 1'b0)));
        check(hi_min == 5 && hi_max == 5, "R5 pulse width", hi_max, 5);
        check(lo_min == 5, "R5 null width", lo_min, 5);
        tx_go = 1'b0;

        // R7 even parity
        clear_mon();
        par_even = 1'b1;
        load_word(16'h00FF, 16'h0F0F);
        tx_go = 1'b1;
        wait_ready(2000);
        check(rx_words[0] == frame(16'h00FF, 16'h0F0F, 1'b1), "R7 even frame", int'(rx_words[0]), int'(frame(16'h00FF, 16'h0F0F, 1'b1)));
        tx_go = 1'b0; par_even = 1'b0;

        // R2 nine loads, eight kept; R5 gap
        clear_mon();
        for (int i = 0; i < 9; i++) load_word(16'h1100 + 16'(i), 16'hC000 + 16'(i * 7));
        check(tx_ready == 1'b0, "R3 ready low with queue", int'(tx_ready), 0);
        tx_go = 1'b1;
        wait_ready(20000);
        check(rx_cnt == 8, "R2 eight of nine sent", rx_cnt, 8);
        check(rx_words[7] == frame(16'h1107, 16'hC000 + 16'(49), 1'b0), "R2 last kept word", int'(rx_words[7]), int'(frame(16'h1107, 16'hC000 + 16'(49), 1'b0)));
        check(lo_max == 45, "R5 word gap", lo_max, 45);
        tx_go = 1'b0;

        // R11 load during transmission
        clear_mon();
        load_word(16'h3C3C, 16'hBEEF);
        tx_go = 1'b1;
        repeat (50) @(negedge clk);
        load_word(16'hC3C3, 16'h0042);
        wait_ready(4000);
        check(rx_cnt == 2, "R11 two words", rx_cnt, 2);
        check(rx_words[0] == frame(16'h3C3C, 16'hBEEF, 1'b0), "R11 first undisturbed", int'(rx_words[0]), int'(frame(16'h3C3C, 16'hBEEF, 1'b0)));
        check(rx_words[1] == frame(16'hC3C3, 16'h0042, 1'b0), "R11 second queued", int'(rx_words[1]), int'(frame(16'hC3C3, 16'h0042, 1'b0)));
        tx_go = 1'b0;

        // R10 fast tick period
        ticks = 0; prev_t = tick_out;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick_out && !prev_t) ticks++;
            prev_t = tick_out;
        end
        check(ticks == 10, "R10 fast tick count", ticks, 10);

        // R6 slow rate, two words
        slow_rate = 1'b1;
        clear_mon();
        load_word(16'h5A5A, 16'h8001);
        load_word(16'h0001, 16'h7FFE);
        tx_go = 1'b1;
        wait_ready(12000);
        check(rx_cnt == 2, "R6 slow words", rx_cnt, 2);
        check(hi_min == 40 && hi_max == 40, "R6 slow pulse", hi_max, 40);
        check(lo_min == 40, "R6 slow null", lo_min, 40);
        check(lo_max == 360, "R6 slow gap", lo_max, 360);
        check(rx_words[1] == frame(16'h0001, 16'h7FFE, 1'b0), "R6 R8 slow frame", int'(rx_words[1]), int'(frame(16'h0001, 16'h7FFE, 1'b0)));
        tx_go = 1'b0;

        // R6 rate held within a frame
        clear_mon();
        load_word(16'hFFFF, 16'hFFFF);
        tx_go = 1'b1;
        repeat (100) @(negedge clk);
        slow_rate = 1'b0;
        wait_ready(6000);
        check(hi_min == 40 && hi_max == 40, "R6 rate latched", hi_min, 40);
        tx_go = 1'b0;

        // R9 reset during a frame
        load_word(16'h1357, 16'h2468);
        load_word(16'h9999, 16'h6666);
        tx_go = 1'b1;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!line_one && !line_zero, "R9 lines drop at once", int'({line_one, line_zero}), 0);
        check(tx_ready == 1'b1, "R9 ready at once", int'(tx_ready), 1);
        @(negedge clk); rst_n = 1'b1;
        clear_mon();
        repeat (200) @(negedge clk);
        check(rx_cnt == 0 && !seen, "R9 queue emptied", rx_cnt, 0);
        check(tx_ready == 1'b1, "R9 ready after release", int'(tx_ready), 1);
        tx_go = 1'b0;

        // R1 simultaneous strobes ignored
        @(negedge clk); lo_stb = 1'b1; bus_in = 16'h0101;
        @(negedge clk); hi_stb = 1'b1;
        @(negedge clk); lo_stb = 1'b0; hi_stb = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_ready == 1'b1, "R1 overlapped strobe ignored", int'(tx_ready), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule